// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a stream of input cycles by a programmable integer N. An input cycle is a clock cycle in which the enable input is high. Internally, a prescaler alternates between two moduli, P and P+1. A swallow count A and a main count B set how many prescaler cycles make up one output period. The prescaler uses P+1 while swallow cycles remain and P for the rest. Each output period is therefore N = B·P + A input cycles long. This gives integer steps of one input cycle instead of steps of P. One select bit picks the modulus pair, either 8/9 or 32/33.

The A, B and pair-select values come from holding registers outside the block. The block copies them into its active setting only at a period boundary, after a reset, or when it wakes from the stopped state. A period that has started is therefore never cut short or stretched. A setting with B smaller than A is illegal. The block flags it and keeps dividing with the last legal setting. A legal setting with B = 0 stops the output.

Each period ends with a single-cycle pulse meant for a phase detector. The modulus-control line is also brought out so that the swallow phase can be observed.

Top module: `swallow_div`

## Requirements
- R1: With pair select psel_i = 0 (P = 8) or psel_i = 1 (P = 32), exactly B·P + A input cycles lie between consecutive output pulses. The first pulse after a reset or wake-up comes after B·P + A input cycles.
- R2: pulse_o is registered. It is high for exactly one clock, namely the clock after the rising edge that consumes the last input cycle of a period.
- R3: mc_o (1 = divide by P+1, 0 = divide by P) is high during the first A·(P+1) input cycles of a period and low for the remaining (B−A)·P. This also holds for the boundary case A = B.
- R4: Only clocks with en_i high count as input cycles. Clocks with en_i low advance neither the prescaler nor the counters.
- R5: a_i, b_i and psel_i are sampled only at the edge that ends a period, at a reset edge, or while stopped. Changes during a period do not alter that period's length.
- R6: err_o is high in every cycle in which b_i < a_i (combinational on the inputs). Such a setting never becomes active, and division continues with the last legal setting.
- R7: A = 0 gives a period of B·P input cycles, with mc_o low throughout.
- R8: A legal setting with B = 0 stops output pulses. While stopped, a legal setting with B ≠ 0 is taken at the next clock edge whatever the state of en_i. Its first period starts with the next input cycle.
- R9: A synchronous reset loads the inputs as the active setting if they are legal and stops the block otherwise. During reset, pulse_o is low, mc_o equals (A ≠ 0), and the period count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Input-cycle enable: each clock with en_i high is one cycle to divide |
| psel_i | input | 1 | Modulus pair: 0 selects 8/9, 1 selects 32/33 |
| a_i | input | 5 | Swallow count A from its holding register |
| b_i | input | 13 | Main count B from its holding register |
| pulse_o | output | 1 | One-clock pulse at the end of each period |
| mc_o | output | 1 | Modulus control: 1 while dividing by P+1 |
| err_o | output | 1 | High while the held setting has B < A |

## Verification
pulse_o and mc_o come from registers. They reflect the rising edge just passed, so the pulse for a period appears in the clock after the edge that takes its last input cycle. mc_o shows the modulus of the next input cycle. err_o is combinational and is due in the same cycle as the inputs that cause it. The bench holds its inputs steady across each rising edge and samples at the falling edge. At that point it advances a reference model by one edge, using the inputs that edge saw. It then compares all three outputs against the model, so every result is checked exactly in the cycle it is due.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
    localparam int unsigned SWDIV_A_W  = 5;
    localparam int unsigned SWDIV_B_W  = 13;
    localparam int unsigned SWDIV_P_LO = 8;
    localparam int unsigned SWDIV_P_HI = 32;

    typedef enum logic {
        MOD_BASE    = 1'b0,
        MOD_SWALLOW = 1'b1
    } mod_e;
endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
    import swdiv_pkg::*;
#(
    parameter int unsigned P_LO = SWDIV_P_LO,
    parameter int unsigned P_HI = SWDIV_P_HI
) (
    input  logic clk,
    input  logic load_i,
    input  logic en_i,
    input  logic wide_i,
    input  logic swallow_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(P_HI + 1);
    localparam logic [CW-1:0] TOP_LO = CW'(P_LO);
    localparam logic [CW-1:0] TOP_HI = CW'(P_HI);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    mod_e          mode;
    logic [CW-1:0] base;
    logic [CW-1:0] reload;

    always_comb begin
        mode   = swallow_i ? MOD_SWALLOW : MOD_BASE;
        base   = wide_i ? TOP_HI : TOP_LO;
        reload = (mode == MOD_SWALLOW) ? base : base - CW'(1);
        st_d   = st_q;
        if (load_i) begin
            st_d.cnt = reload;
        end else if (en_i) begin
            st_d.cnt = (st_q.cnt == '0) ? reload : st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign done_o = en_i && (st_q.cnt == '0);
endmodule

// File: rtl/swdiv_counters.sv
module swdiv_counters
    import swdiv_pkg::*;
#(
    parameter int unsigned A_W = SWDIV_A_W,
    parameter int unsigned B_W = SWDIV_B_W
) (
    input  logic           clk,
    input  logic           load_i,
    input  logic [A_W-1:0] a_ld_i,
    input  logic [B_W-1:0] b_ld_i,
    input  logic           step_i,
    output logic [A_W-1:0] a_o,
    output logic [B_W-1:0] b_o,
    output logic           last_o,
    output logic           swallow_nx_o
);
    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.a = a_ld_i;
            st_d.b = b_ld_i;
        end else if (step_i && (st_q.b != '0)) begin
            st_d.b = st_q.b - B_W'(1);
            st_d.a = (st_q.a != '0) ? st_q.a - A_W'(1) : '0;
        end
        swallow_nx_o = (st_d.a != '0);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign a_o    = st_q.a;
    assign b_o    = st_q.b;
    assign last_o = step_i && (st_q.b == B_W'(1));
endmodule

// File: rtl/swallow_div.sv
module swallow_div
    import swdiv_pkg::*;
#(
    parameter int unsigned A_W  = SWDIV_A_W,
    parameter int unsigned B_W  = SWDIV_B_W,
    parameter int unsigned P_LO = SWDIV_P_LO,
    parameter int unsigned P_HI = SWDIV_P_HI
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_i,
    input  logic           psel_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic           pulse_o,
    output logic           mc_o,
    output logic           err_o
);
    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic           wide;
        logic           pulse;
    } top_st_t;

    top_st_t        st_d, st_q;
    logic [A_W-1:0] ctr_a;
    logic [B_W-1:0] ctr_b;
    logic           ctr_last;
    logic           ctr_load;
    logic           pre_done;
    logic           swallow_nx;
    logic           cfg_ok;
    logic           idle;

    always_comb begin
        cfg_ok   = (B_W'(a_i) <= b_i);
        idle     = (ctr_b == '0);
        ctr_load = rst || ctr_last || (idle && cfg_ok && (b_i != '0));
        st_d       = st_q;
        st_d.pulse = ctr_last && !rst;
        if (ctr_load && cfg_ok) begin
            st_d.a    = a_i;
            st_d.b    = b_i;
            st_d.wide = psel_i;
        end else if (rst) begin
            st_d.a    = '0;
            st_d.b    = '0;
            st_d.wide = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    swdiv_prescaler #(
        .P_LO(P_LO),
        .P_HI(P_HI)
    ) u_pre (
        .clk      (clk),
        .load_i   (ctr_load),
        .en_i     (en_i),
        .wide_i   (st_d.wide),
        .swallow_i(swallow_nx),
        .done_o   (pre_done)
    );

    swdiv_counters #(
        .A_W(A_W),
        .B_W(B_W)
    ) u_ctr (
        .clk         (clk),
        .load_i      (ctr_load),
        .a_ld_i      (st_d.a),
        .b_ld_i      (st_d.b),
        .step_i      (pre_done),
        .a_o         (ctr_a),
        .b_o         (ctr_b),
        .last_o      (ctr_last),
        .swallow_nx_o(swallow_nx)
    );

    assign pulse_o = st_q.pulse;
    assign mc_o    = (ctr_a != '0);
    assign err_o   = !cfg_ok;
endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk #(
    parameter int unsigned A_W = 5,
    parameter int unsigned B_W = 13
) (
    input logic           clk,
    input logic           rst,
    input logic           pulse_o,
    input logic           mc_o,
    input logic           err_o,
    input logic           ctr_last,
    input logic [A_W-1:0] ctr_a,
    input logic [B_W-1:0] ctr_b,
    input logic [A_W-1:0] act_a,
    input logic [B_W-1:0] act_b,
    input logic           act_wide
);
    p_pulse_after_last_r1: assert property (@(posedge clk) disable iff (rst)
        ctr_last |=> pulse_o);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

    p_swallow_bound_r3: assert property (@(posedge clk) disable iff (rst)
        B_W'(ctr_a) <= ctr_b);

    p_start_mode_r3: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> (mc_o == (act_a != '0)));

    p_mid_period_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctr_last && (ctr_b != '0)) |=> $stable({act_a, act_b, act_wide}));

    p_illegal_hold_r6: assert property (@(posedge clk) disable iff (rst)
        err_o |=> $stable({act_a, act_b, act_wide}));
endmodule

bind swallow_div swallow_div_chk #(
    .A_W(A_W),
    .B_W(B_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pulse_o (pulse_o),
    .mc_o    (mc_o),
    .err_o   (err_o),
    .ctr_last(ctr_last),
    .ctr_a   (ctr_a),
    .ctr_b   (ctr_b),
    .act_a   (st_q.a),
    .act_b   (st_q.b),
    .act_wide(st_q.wide)
);

// File: tb/swallow_div_tb_top.sv
module swallow_div_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        psel = 1'b0;
    logic [4:0]  a_in = '0;
    logic [12:0] b_in = '0;
    logic        pulse_o, mc_o, err_o;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    m_run = 0;
    int    m_a = 0, m_p = 8, m_n = 0, cnt = 0;
    bit    last_exp = 0;
    bit    en_rand = 0;
    string tag = "R9";

    always #4 clk = ~clk;

    swallow_div dut_i (
        .clk(clk), .rst(rst), .en_i(en), .psel_i(psel),
        .a_i(a_in), .b_i(b_in),
        .pulse_o(pulse_o), .mc_o(mc_o), .err_o(err_o)
    );

    function automatic int ratio(int b, int a, bit wide);
        return b * (wide ? 32 : 8) + a;
    endfunction

    task automatic expect_eq(string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic take_cfg();
        m_a   = int'(a_in);
        m_p   = psel ? 32 : 8;
        m_n   = ratio(int'(b_in), int'(a_in), psel);
        m_run = 1;
    endtask

    task automatic tick();
        bit ok;
        bit exp_p;
        @(negedge clk);
        ok    = (int'(b_in) >= int'(a_in));
        exp_p = 0;
        if (rst) begin
            cnt = 0;
            if (ok && b_in != 0) take_cfg();
            else begin m_run = 0; m_a = 0; end
        end else if (!m_run) begin
            if (ok && b_in != 0) begin take_cfg(); cnt = 0; end
        end else begin
            if (en) cnt++;
            if (cnt == m_n) begin
                exp_p = 1;
                cnt   = 0;
                if (ok) begin
                    if (b_in != 0) take_cfg();
                    else begin m_run = 0; m_a = 0; end
                end
            end
        end
        last_exp = exp_p;
        expect_eq("pulse R1 R2", int'(pulse_o), int'(exp_p));
        expect_eq("mc R3", int'(mc_o), int'(m_run && (cnt < m_a * (m_p + 1))));
        expect_eq("err R6", int'(err_o), int'(!ok));
    endtask

    task automatic set_cfg(int a, int b, bit wide);
        a_in = 5'(a);
        b_in = 13'(b);
        psel = wide;
    endtask

    task automatic run_pulses(int k);
        int seen = 0;
        int guard = 0;
        while (seen < k && guard < 6000) begin
            if (en_rand) en = (($urandom % 4) != 0);
            tick();
            if (last_exp) seen++;
            guard++;
        end
    endtask

    task automatic run_ticks(int k);
        for (int i = 0; i < k; i++) begin
            if (en_rand) en = (($urandom % 4) != 0);
            tick();
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R9: reset loads a legal setting; mc_o reflects A during reset
        tag = "R9";
        set_cfg(3, 5, 1'b0);
        en = 1'b1;
        run_ticks(3);
        rst = 1'b0;
        // R1: basic division, 8/9 pair
        tag = "R1";
        run_pulses(3);
        // R7: A = 0 with the 32/33 pair
        tag = "R7";
        set_cfg(0, 4, 1'b1);
        run_pulses(3);
        // R3: boundary A = B, every prescaler cycle swallows
        tag = "R3";
        set_cfg(31, 31, 1'b0);
        run_pulses(2);
        set_cfg(2, 2, 1'b1);
        run_pulses(2);
        // R4: gaps in the enable
        tag = "R4";
        en_rand = 1;
        set_cfg(5, 9, 1'b0);
        run_pulses(3);
        en_rand = 0;
        en = 1'b1;
        // R5: a change mid-period only lands at the boundary
        tag = "R5";
        run_ticks(10);
        set_cfg(1, 3, 1'b1);
        run_pulses(3);
        run_ticks(17);
        set_cfg(4, 6, 1'b0);
        run_pulses(2);
        // R6: an illegal setting is flagged and ignored
        tag = "R6";
        set_cfg(9, 4, 1'b1);
        run_pulses(3);
        // R8: B = 0 stops output; wake-up ignores en_i
        tag = "R8";
        set_cfg(0, 0, 1'b0);
        run_pulses(1);
        run_ticks(300);
        en = 1'b0;
        set_cfg(2, 3, 1'b0);
        run_ticks(4);
        en = 1'b1;
        run_pulses(2);
        // R9: reset in mid-period restarts the count
        tag = "R9";
        run_ticks(13);
        set_cfg(1, 2, 1'b1);
        rst = 1'b1;
        run_ticks(2);
        rst = 1'b0;
        run_pulses(2);
        // R1: random legal settings, changed at random points
        tag = "R1";
        for (int i = 0; i < 40; i++) begin
            int b;
            int a;
            int amax;
            b    = 1 + int'($urandom % 30);
            amax = (b < 31) ? b : 31;
            a    = int'($urandom % (amax + 1));
            en_rand = (($urandom % 3) == 0);
            run_ticks(int'($urandom % 40));
            set_cfg(a, b, 1'($urandom % 2));
            run_pulses(2);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule